// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Hold Handshake

This block keeps wall-clock time and date in BCD: seconds, minutes, hours (24-hour), weekday, day of month, month and a two-digit year. It is clocked by the system clock and advanced by a one-cycle `tick_i` strobe from a 32.768 kHz source. A prescaler turns a parameterised number of ticks into one second step, and a carry chain applies each field's rollover, including month lengths and 29 February in leap years.

Software reaches the block over a simple 32-bit register bus. It has a write strobe and a combinational read port. The running time is read from one bank of registers. A new time is written into a separate staging bank. To set the time, software asks for a hold and waits until the stop flag reads 1. It then fills the staging bank and clears the hold. Clearing the hold copies the staging bank into the running counters, and counting restarts from the start of a fresh second.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the running time reads seconds 0x00, minutes 0x00, hours 0x00, weekday 0x00, day 0x01, month 0x01, year 0x00. The staging bank holds the same values. Control offsets 0x00, 0x04 and 0x08 read 0.
- R2: Offset 0x00 keeps bit 7 (count enable) and bit 5 (24-hour select) and reads every other bit as 0. While bit 7 is 0, tick pulses do not advance the time.
- R3: While the block is running, the seconds field advances by one BCD step on every TICKS_PER_SEC-th `tick_i` pulse. Cycles with `tick_i` low do not count toward a second.
- R4: Seconds and minutes wrap from 0x59 to 0x00 and carry into the next field. Hours wrap from 0x23 to 0x00 and carry into the day.
- R5: The day wraps to 0x01 after the last day of its month: 30 for months 04, 06, 09 and 11; 31 for the other months; 28 for month 02, or 29 when the year value is divisible by 4. The month wraps from 0x12 to 0x01 and carries into the year. The year wraps from 0x99 to 0x00.
- R6: The weekday (0 = Sunday) advances by one on each day carry and wraps from 0x06 to 0x00.
- R7: Writing offset 0x08 with bit 0 = 1 sets the hold request, which reads back in bit 0. Bit 1, the stop flag, reads 1 after the second `tick_i` pulse that follows the request.
- R8: The time does not advance while the hold request or the stop flag is set.
- R9: The staging registers sit at offsets 0x14, 0x18, 0x1c, 0x20, 0x24, 0x28 and 0x2c (seconds, minutes, hours, weekday, day, month, year) and read back at the same offsets. A write to them is ignored unless the stop flag is 1.
- R10: Writing offset 0x08 with bit 0 = 0 clears both bits. If the stop flag was 1, the running counters take the staging values and the prescaler restarts at zero. If the stop flag was 0, the counters keep their values.
- R11: Offset 0x04 keeps bit 4 (alarm enable) and reads every other bit as 0. The bit has no effect on the time.
- R12: The running time reads at offsets 0x4c to 0x64, in steps of 4, in the staging field order. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe from the 32.768 kHz source |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |

## Verification
Reads are combinational, so the bench samples one time unit after it drives the address, away from any clock edge. Every register change takes effect at the clock edge that carries its write or tick pulse. The bench drives each tick on its own cycle and reads after that cycle has ended. It therefore expects the stop flag exactly after the second tick that follows the hold request, and a new second exactly after the TICKS_PER_SEC-th running tick. A load takes effect at the edge that carries the release write, so the time is read straight after that write.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;
  localparam int unsigned N_FIELDS = 7;
  typedef logic [7:0] bcd_t;

  localparam int unsigned FLD_SEC = 0;
  localparam int unsigned FLD_MIN = 1;
  localparam int unsigned FLD_HR  = 2;
  localparam int unsigned FLD_WD  = 3;
  localparam int unsigned FLD_DAY = 4;
  localparam int unsigned FLD_MON = 5;
  localparam int unsigned FLD_YR  = 6;

  localparam logic [7:0] OFS_CTL0     = 8'h00;
  localparam logic [7:0] OFS_CTL1     = 8'h04;
  localparam logic [7:0] OFS_CTL2     = 8'h08;
  localparam logic [7:0] OFS_SET_BASE = 8'h14;
  localparam logic [7:0] OFS_NOW_BASE = 8'h4c;

  function automatic bcd_t reset_val(int unsigned idx);
    return (idx == FLD_DAY || idx == FLD_MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic bcd_t bcd_inc(bcd_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // divisible by 4 in BCD: even tens -> units 0/4/8, odd tens -> units 2/6
  function automatic logic leap_yr(bcd_t y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic bcd_t month_last(bcd_t m, bcd_t y);
    if (m == 8'h02) return leap_yr(y) ? 8'h29 : 8'h28;
    if (m == 8'h04 || m == 8'h06 || m == 8'h09 || m == 8'h11) return 8'h30;
    return 8'h31;
  endfunction
endpackage

// File: rtl/bcd_rtc_prescaler.sv
module bcd_rtc_prescaler #(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic clr_i,
  output logic step_o
);
  localparam int unsigned CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  assign step_o = run_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || step_o)    cnt_q <= '0;
    else if (run_i && tick_i)    cnt_q <= cnt_q + CW'(1);
  end

  p_step_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> (run_i && tick_i));
  p_cnt_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/bcd_rtc_hold.sv
module bcd_rtc_hold #(
  parameter int unsigned STOP_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ctl_we_i,
  input  logic hold_bit_i,
  output logic hold_o,
  output logic stopped_o,
  output logic load_o
);
  localparam int unsigned CW = $clog2(STOP_TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          hold_q, stopped_q;

  assign hold_o    = hold_q;
  assign stopped_o = stopped_q;
  assign load_o    = ctl_we_i && !hold_bit_i && stopped_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0; stopped_q <= 1'b0; cnt_q <= '0;
    end else if (ctl_we_i && !hold_bit_i) begin
      hold_q <= 1'b0; stopped_q <= 1'b0; cnt_q <= '0;
    end else if (ctl_we_i && !hold_q) begin
      hold_q <= 1'b1; cnt_q <= '0;
    end else if (hold_q && !stopped_q && tick_i) begin
      if (cnt_q == CW'(STOP_TICKS - 1)) stopped_q <= 1'b1;
      else                              cnt_q <= cnt_q + CW'(1);
    end
  end

  p_stop_needs_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped_q |-> hold_q);
  p_stop_on_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stopped_q) |-> $past(tick_i));
  p_release_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && !hold_bit_i) |=> (!hold_q && !stopped_q));
endmodule

// File: rtl/bcd_rtc_calendar.sv
module bcd_rtc_calendar
  import bcd_rtc_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    step_i,
  input  logic                    load_i,
  input  logic [N_FIELDS-1:0][7:0] load_val_i,
  output logic [N_FIELDS-1:0][7:0] time_o
);
  logic [N_FIELDS-1:0][7:0] t_q, t_nxt;
  logic c_sec, c_min, c_hr, c_day, c_mon;

  always_comb begin
    t_nxt = t_q;
    c_sec = t_q[FLD_SEC] == 8'h59;
    c_min = c_sec && (t_q[FLD_MIN] == 8'h59);
    c_hr  = c_min && (t_q[FLD_HR] == 8'h23);
    c_day = c_hr && (t_q[FLD_DAY] == month_last(t_q[FLD_MON], t_q[FLD_YR]));
    c_mon = c_day && (t_q[FLD_MON] == 8'h12);
    t_nxt[FLD_SEC] = c_sec ? 8'h00 : bcd_inc(t_q[FLD_SEC]);
    if (c_sec) t_nxt[FLD_MIN] = c_min ? 8'h00 : bcd_inc(t_q[FLD_MIN]);
    if (c_min) t_nxt[FLD_HR]  = c_hr  ? 8'h00 : bcd_inc(t_q[FLD_HR]);
    if (c_hr) begin
      t_nxt[FLD_WD]  = (t_q[FLD_WD] == 8'h06) ? 8'h00 : bcd_inc(t_q[FLD_WD]);
      t_nxt[FLD_DAY] = c_day ? 8'h01 : bcd_inc(t_q[FLD_DAY]);
    end
    if (c_day) t_nxt[FLD_MON] = c_mon ? 8'h01 : bcd_inc(t_q[FLD_MON]);
    if (c_mon) t_nxt[FLD_YR]  = (t_q[FLD_YR] == 8'h99) ? 8'h00 : bcd_inc(t_q[FLD_YR]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int unsigned i = 0; i < N_FIELDS; i++) t_q[i] <= reset_val(i);
    end else if (load_i) t_q <= load_val_i;
    else if (step_i)     t_q <= t_nxt;
  end

  assign time_o = t_q;

  p_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(t_q));
  p_sec_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && t_q[FLD_SEC] == 8'h59) |=> (t_q[FLD_SEC] == 8'h00));
  p_year_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && c_mon && t_q[FLD_YR] == 8'h99)
      |=> (t_q[FLD_YR] == 8'h00 && t_q[FLD_MON] == 8'h01 && t_q[FLD_DAY] == 8'h01));
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import bcd_rtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned STOP_TICKS    = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        bus_we_i,
  input  logic [7:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o
);
  logic ce_q, h24_q, alm_en_q;
  logic hold, stopped, load, run, step;
  logic [N_FIELDS-1:0][7:0] set_val, now_val;

  assign run = ce_q && !hold && !stopped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q <= 1'b0; h24_q <= 1'b0; alm_en_q <= 1'b0;
    end else if (bus_we_i) begin
      if (bus_addr_i == OFS_CTL0) begin
        ce_q  <= bus_wdata_i[7];
        h24_q <= bus_wdata_i[5];
      end
      if (bus_addr_i == OFS_CTL1) alm_en_q <= bus_wdata_i[4];
    end
  end

  // staging bank, writable only once the counters are stopped
  for (genvar g = 0; g < N_FIELDS; g++) begin : g_set
    localparam logic [7:0] OFS = OFS_SET_BASE + 8'(4 * g);
    bcd_t fld_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fld_q <= reset_val(g);
      else if (bus_we_i && stopped && bus_addr_i == OFS) fld_q <= bus_wdata_i[7:0];
    end
    assign set_val[g] = fld_q;
  end

  bcd_rtc_hold #(.STOP_TICKS(STOP_TICKS)) i_hold (
    .clk_i, .rst_ni, .tick_i,
    .ctl_we_i  (bus_we_i && bus_addr_i == OFS_CTL2),
    .hold_bit_i(bus_wdata_i[0]),
    .hold_o    (hold),
    .stopped_o (stopped),
    .load_o    (load)
  );

  bcd_rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) i_presc (
    .clk_i, .rst_ni, .tick_i,
    .run_i (run),
    .clr_i (load),
    .step_o(step)
  );

  bcd_rtc_calendar i_cal (
    .clk_i, .rst_ni,
    .step_i    (step),
    .load_i    (load),
    .load_val_i(set_val),
    .time_o    (now_val)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      OFS_CTL0: bus_rdata_o = {24'd0, ce_q, 1'b0, h24_q, 5'd0};
      OFS_CTL1: bus_rdata_o = {27'd0, alm_en_q, 4'd0};
      OFS_CTL2: bus_rdata_o = {30'd0, stopped, hold};
      default: begin
        for (int unsigned i = 0; i < N_FIELDS; i++) begin
          if (bus_addr_i == OFS_SET_BASE + 8'(4 * i)) bus_rdata_o = {24'd0, set_val[i]};
          if (bus_addr_i == OFS_NOW_BASE + 8'(4 * i)) bus_rdata_o = {24'd0, now_val[i]};
        end
      end
    endcase
  end

  p_setbank_guard_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stopped |=> $stable(set_val));
  p_no_run_in_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold || stopped) |-> !step);
endmodule

// File: tb/test_bcd_rtc.sv
module test_bcd_rtc;
  localparam int CLK_PERIOD = 10;
  localparam int TPS = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  int vectors = 0, fails = 0;
  int m_sec, m_min, m_hr, m_wd, m_day, m_mon, m_yr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bcd_rtc #(.TICKS_PER_SEC(TPS)) i_bcd_rtc (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata)
  );

  function automatic logic [31:0] to_bcd(int v);
    return 32'((v / 10) * 16 + v % 10);
  endfunction

  function automatic int days_in(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_second();
    m_sec++;
    if (m_sec == 60) begin m_sec = 0; m_min++; end
    if (m_min == 60) begin m_min = 0; m_hr++; end
    if (m_hr == 24) begin
      m_hr = 0; m_wd = (m_wd + 1) % 7; m_day++;
      if (m_day > days_in(m_mon, m_yr)) begin m_day = 1; m_mon++; end
      if (m_mon == 13) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic advance(input int secs);
    tick_n(secs * TPS);
    for (int i = 0; i < secs; i++) model_second();
  endtask

  task automatic check_time(input string req);
    logic [31:0] d;
    int exp[7];
    exp = '{m_sec, m_min, m_hr, m_wd, m_day, m_mon, m_yr};
    for (int i = 0; i < 7; i++) begin
      rd(8'h4c + 8'(4 * i), d);
      chk(req, d, to_bcd(exp[i]));
    end
  endtask

  task automatic set_time(input int s, mi, h, w, dy, mo, y);
    logic [31:0] d;
    int v[7];
    v = '{s, mi, h, w, dy, mo, y};
    wr(8'h08, 32'h1);
    tick_n(2);
    rd(8'h08, d); chk("R7 stop flag", d, 32'h3);
    for (int i = 0; i < 7; i++) wr(8'h14 + 8'(4 * i), to_bcd(v[i]));
    wr(8'h08, 32'h0);
    m_sec = s; m_min = mi; m_hr = h; m_wd = w; m_day = dy; m_mon = mo; m_yr = y;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    m_sec = 0; m_min = 0; m_hr = 0; m_wd = 0; m_day = 1; m_mon = 1; m_yr = 0;
    check_time("R1 reset time");
    rd(8'h00, d); chk("R1 ctl0", d, 0);
    rd(8'h04, d); chk("R1 ctl1", d, 0);
    rd(8'h08, d); chk("R1 ctl2", d, 0);
    rd(8'h24, d); chk("R1 staging day", d, 32'h01);

    // R2 disabled counter ignores ticks
    tick_n(3 * TPS);
    check_time("R2 disabled");
    wr(8'h00, 32'hFF);
    rd(8'h00, d); chk("R2 ctl0 bits", d, 32'hA0);

    // R11 alarm enable bit stored, inert
    wr(8'h04, 32'hFF);
    rd(8'h04, d); chk("R11 ctl1 bit", d, 32'h10);

    // R12 unmapped
    rd(8'h10, d); chk("R12 unmapped", d, 0);
    rd(8'h70, d); chk("R12 unmapped", d, 0);

    // R3 prescaler
    tick_n(TPS - 1);
    repeat (10) @(negedge clk);
    check_time("R3 partial second");
    tick_n(1); model_second();
    check_time("R3 full second");

    // R9 staging write ignored while running
    wr(8'h14, 32'h45);
    rd(8'h14, d); chk("R9 ignored write", d, 0);

    // R7 handshake timing, R8 freeze under request
    wr(8'h08, 32'h1);
    rd(8'h08, d); chk("R7 req", d, 32'h1);
    tick_n(1);
    rd(8'h08, d); chk("R7 one tick", d, 32'h1);
    tick_n(1);
    rd(8'h08, d); chk("R7 two ticks", d, 32'h3);
    tick_n(2 * TPS);
    check_time("R8 frozen");

    // R9 / R10 load through the handshake
    for (int i = 0; i < 7; i++) begin
      int v[7];
      v = '{58, 59, 23, 6, 31, 12, 99};
      wr(8'h14 + 8'(4 * i), to_bcd(v[i]));
    end
    rd(8'h2c, d); chk("R9 staging year", d, 32'h99);
    wr(8'h08, 32'h0);
    rd(8'h08, d); chk("R10 release", d, 0);
    m_sec = 58; m_min = 59; m_hr = 23; m_wd = 6; m_day = 31; m_mon = 12; m_yr = 99;
    check_time("R10 loaded");

    // R4 R5 R6 full rollover
    advance(1); check_time("R4 59 s");
    advance(1); check_time("R5 R6 year wrap");

    // R5 month lengths
    set_time(59, 59, 23, 3, 28, 2, 24); advance(1); check_time("R5 leap feb 28");
    set_time(59, 59, 23, 4, 29, 2, 24); advance(1); check_time("R5 leap feb 29");
    set_time(59, 59, 23, 2, 28, 2, 23); advance(1); check_time("R5 feb 28");
    set_time(59, 59, 23, 0, 30, 4, 10); advance(1); check_time("R5 apr 30");
    set_time(59, 59, 23, 1, 30, 5, 10); advance(1); check_time("R5 may 30");
    set_time(50, 59, 12, 2, 15, 7, 42); advance(15); check_time("R4 minute carry");

    // R10 release without stop: no load
    wr(8'h08, 32'h1);
    wr(8'h08, 32'h0);
    check_time("R10 no load");
    advance(2); check_time("R10 resume");

    // random
    for (int it = 0; it < 24; it++) begin
      int mo, yr;
      mo = 1 + int'($urandom % 12);
      yr = int'($urandom % 100);
      set_time(int'($urandom % 60), int'($urandom % 60), int'($urandom % 24),
               int'($urandom % 7), 1 + int'($urandom % days_in(mo, yr)), mo, yr);
      advance(1 + int'($urandom % 80));
      check_time("R3 R4 R5 R6 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule